// File: doc/BRIEF.md
# Burst-of-Two Common-I/O SRAM Sequencer

This block models a pipelined double-data-rate SRAM whose single data bus is shared by reads and writes. Every command moves exactly two data words. The bus is split here into a data-in bus, a data-out bus and an output-enable. The block runs on a beat clock `clk` at twice the K rate. Beat edges alternate between K-rise edges and K#-rise edges. After reset is released, the first rising edge of `clk` is a K-rise edge. The load strobe, the read/write select and the address are sampled only on K-rise edges.

A read returns its data one K cycle after it was taken, because reads are pipelined. A write takes its data one K cycle after the command, because writes are late. A completed write waits in a one-entry buffer and is committed to the array on the next K-rise edge. A read taken in the K cycle right after a write to the same aligned pair is served from that buffer. A deselect goes through the same pipeline as a read. Bursts already in flight therefore finish before the output drivers turn off.

Top module: `sram_b2_seq`

## Requirements
- R1: Each read or write moves two words. The first uses the command address A and the second uses A with bit 0 inverted, so the burst wraps inside the aligned pair. Once a read's first beat has been driven, its second beat always follows in the next beat slot.
- R2: The inputs `ldN`, `rwN` and `addr` have no effect on K#-rise edges. Any values there produce no output-enable slots and change no stored word.
- R3: On a K-rise edge the command is decoded as follows: `ldN`=0 with `rwN`=1 is a read, `ldN`=0 with `rwN`=0 is a write, and `ldN`=1 is a deselect that takes no command.
- R4: For a read taken on K-rise edge e, `oe` is 1 and `dOut` holds word A after edge e+3, which is a K#-rise edge. The word at A with bit 0 inverted is driven after edge e+4.
- R5: For a write taken on K-rise edge e, `dIn` is captured on edge e+2 as the word for A and on edge e+3 as the word for A with bit 0 inverted.
- R6: `oe` is 1 only in the two beat slots of a read. This includes slots that follow a deselect issued right after a read, where the pending read completes first. `oe` is 0 in every other slot, including the write capture slots.
- R7: A read taken on the K-rise edge right after a write to the same aligned pair returns the newly written words, in either beat order.
- R8: `dOut` is zero whenever `oe` is 0.
- R9: Reset (`rstN` low, asynchronous) clears `oe`, `dOut`, all stored words and the command pipeline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat clock; its edges alternate between K rise and K# rise |
| rstN | input | 1 | Asynchronous active-low reset |
| ldN | input | 1 | Active-low load strobe, sampled on K-rise edges |
| rwN | input | 1 | High selects read, low selects write |
| addr | input | ADDR_W | Word address of the burst's first beat |
| dIn | input | DATA_W | Write data, one word per beat slot |
| dOut | output | DATA_W | Read data, zero when not driving |
| oe | output | 1 | High in read beat slots, standing in for the bus driver enable |

## Verification
The bench first writes every word address, including odd starting addresses. A design that counted the second beat upward instead of wrapping inside the pair would then return wrong neighbours on the later read-back. Alternating write/read pairs to the same pair, in both beat orders, target the late-write buffer. A design without forwarding would return stale array words there. The bench also drives random-looking commands in every K#-rise slot. A design that samples on both edges would produce extra enable slots or corrupt words. Read-then-deselect runs check that a pipelined read still completes and that `oe` then drops, rather than being cut short or left on.

// File: rtl/sram_b2_pkg.sv
package sram_b2_pkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;

  // One-cycle strobes from control to datapath
  typedef struct packed {
    logic fetch;     // read the pair into the read buffer (K rise)
    logic capBeat0;  // capture first write word (K rise)
    logic capBeat1;  // capture second write word (K# rise)
    logic outBeat0;  // drive first read word (K# rise)
    logic outBeat1;  // drive second read word (K rise)
    logic commit;    // move the late-write buffer into the array (K rise)
  } strobe_t;

endpackage

// File: rtl/sram_b2_ctrl.sv
module sram_b2_ctrl
  import sram_b2_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldN,
  input  logic              rwN,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic              kRise
);

  logic half;
  cmd_e stage1Cmd;
  cmd_e stage2Cmd;
  cmd_e decoded;

  assign kRise = !half;

  always_comb begin
    if (ldN)       decoded = CMD_NONE;
    else if (rwN)  decoded = CMD_READ;
    else           decoded = CMD_WRITE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      half      <= 1'b0;
      stage1Cmd <= CMD_NONE;
      stage2Cmd <= CMD_NONE;
      cmdAddr   <= '0;
    end else begin
      half <= !half;
      if (kRise) begin
        stage1Cmd <= decoded;
        stage2Cmd <= stage1Cmd;
        if (!ldN) cmdAddr <= addr;
      end
    end
  end

  always_comb begin
    stb          = '0;
    stb.fetch    = kRise  && (stage1Cmd == CMD_READ);
    stb.capBeat0 = kRise  && (stage1Cmd == CMD_WRITE);
    stb.outBeat1 = kRise  && (stage2Cmd == CMD_READ);
    stb.commit   = kRise  && (stage2Cmd == CMD_WRITE);
    stb.outBeat0 = !kRise && (stage2Cmd == CMD_READ);
    stb.capBeat1 = !kRise && (stage2Cmd == CMD_WRITE);
  end

endmodule

// File: rtl/sram_b2_dp.sv
module sram_b2_dp
  import sram_b2_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              oe
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] PAIR_FLIP = ADDR_W'(1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] pendAddr;
  logic [DATA_W-1:0] pendWord0, pendWord1;
  logic [DATA_W-1:0] rdWord0, rdWord1;
  logic [DATA_W-1:0] fetch0, fetch1;
  logic              pairHit, sameOrder;

  // Forward from the late-write buffer when it commits on this fetch edge
  assign pairHit   = stb.commit && ((cmdAddr >> 1) == (pendAddr >> 1));
  assign sameOrder = (cmdAddr == pendAddr);

  always_comb begin
    if (pairHit) begin
      fetch0 = sameOrder ? pendWord0 : pendWord1;
      fetch1 = sameOrder ? pendWord1 : pendWord0;
    end else begin
      fetch0 = mem[cmdAddr];
      fetch1 = mem[cmdAddr ^ PAIR_FLIP];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (stb.commit) begin
      mem[pendAddr]             <= pendWord0;
      mem[pendAddr ^ PAIR_FLIP] <= pendWord1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendAddr  <= '0;
      pendWord0 <= '0;
      pendWord1 <= '0;
      rdWord0   <= '0;
      rdWord1   <= '0;
    end else begin
      if (stb.capBeat0) begin
        pendAddr  <= cmdAddr;
        pendWord0 <= dIn;
      end
      if (stb.capBeat1) pendWord1 <= dIn;
      if (stb.fetch) begin
        rdWord0 <= fetch0;
        rdWord1 <= fetch1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oe   <= 1'b0;
      dOut <= '0;
    end else if (stb.outBeat0) begin
      oe   <= 1'b1;
      dOut <= rdWord0;
    end else if (stb.outBeat1) begin
      oe   <= 1'b1;
      dOut <= rdWord1;
    end else begin
      oe   <= 1'b0;
      dOut <= '0;
    end
  end

endmodule

// File: rtl/sram_b2_seq.sv
module sram_b2_seq
  import sram_b2_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldN,
  input  logic              rwN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              oe
);

  strobe_t           stb;
  logic [ADDR_W-1:0] cmdAddr;
  logic              kRise;

  sram_b2_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ldN     (ldN),
    .rwN     (rwN),
    .addr    (addr),
    .stb     (stb),
    .cmdAddr (cmdAddr),
    .kRise   (kRise)
  );

  sram_b2_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .cmdAddr (cmdAddr),
    .dIn     (dIn),
    .dOut    (dOut),
    .oe      (oe)
  );

endmodule

// File: rtl/sram_b2_seq_chk.sv
module sram_b2_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ldN,
  input logic              rwN,
  input logic              oe,
  input logic [DATA_W-1:0] dOut,
  input logic              kRise
);

  // R1: a driven first beat is always followed by a second
  p_burst_pair_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oe) |=> oe);

  // R4: a read burst starts in the slot after a K# edge
  p_first_beat_slot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oe) |-> kRise);

  // R4: read accepted on a K rise drives two beats after edges e+3 and e+4
  p_read_latency_r4: assert property (@(posedge clk) disable iff (!rstN)
    (kRise && !ldN && rwN) |-> ##4 oe ##1 oe);

  // R6: deselects and writes own no driven slots
  p_no_drive_r6: assert property (@(posedge clk) disable iff (!rstN)
    (kRise && !(!ldN && rwN)) |-> ##4 !oe ##1 !oe);

  // R8: quiet data bus while not driving
  p_quiet_bus_r8: assert property (@(posedge clk) disable iff (!rstN)
    !oe |-> (dOut == '0));

endmodule

bind sram_b2_seq sram_b2_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .ldN   (ldN),
  .rwN   (rwN),
  .oe    (oe),
  .dOut  (dOut),
  .kRise (kRise)
);

// File: tb/sram_b2_seq_bench.sv
module sram_b2_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NK = 124;       // K cycles in the program
  localparam int NE = 2 * NK;    // beat edges
  localparam int C_IDLE = 0, C_RD = 1, C_WR = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              ldN = 1'b1;
  logic              rwN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] dIn = '0;
  logic [DATA_W-1:0] dOut;
  logic              oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int                cmdK  [NK];
  logic [ADDR_W-1:0] adrK  [NK];
  logic [DATA_W-1:0] w0K   [NK];
  logic [DATA_W-1:0] w1K   [NK];
  logic [DATA_W-1:0] e0K   [NK];
  logic [DATA_W-1:0] e1K   [NK];
  bit                fwdK  [NK];
  logic [DATA_W-1:0] refMem[DEPTH];
  int numReads = 0;
  int oeSlots = 0;

  always #(CLK_PERIOD / 2) clk = !clk;

  sram_b2_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sram_b2_seq (
    .clk(clk), .rstN(rstN), .ldN(ldN), .rwN(rwN), .addr(addr),
    .dIn(dIn), .dOut(dOut), .oe(oe)
  );

  task automatic check(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp, input int e);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s edge %0d actual %0h expected %0h", tag, e, act, exp);
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Build the command program and its expected read data
  task automatic buildProgram;
    for (int k = 0; k < NK; k++) begin
      cmdK[k] = C_IDLE; adrK[k] = '0; fwdK[k] = 0;
      w0K[k] = DATA_W'((k * 29 + 3) & 255);
      w1K[k] = DATA_W'((k * 53 + 17) & 255);
      if (k == 0) begin cmdK[k] = C_RD; adrK[k] = 4'd5; end
      else if (k >= 2 && k < 18) begin cmdK[k] = C_WR; adrK[k] = ADDR_W'(k - 2); end
      else if (k >= 18 && k < 34) begin cmdK[k] = C_RD; adrK[k] = ADDR_W'(k - 18); end
      else if (k >= 34 && k < 66) begin
        if (k % 2 == 0) begin cmdK[k] = C_WR; adrK[k] = ADDR_W'((k * 5) & 15); end
        else begin
          cmdK[k] = C_RD;
          adrK[k] = adrK[k-1] ^ ADDR_W'((k >> 1) & 1);
          fwdK[k] = 1;
        end
      end
      else if (k >= 66 && k < 98) begin
        if (k % 2 == 0) begin cmdK[k] = C_RD; adrK[k] = ADDR_W'(k & 15); end
      end
      else if (k >= 98 && k < 120) begin
        cmdK[k] = ((k % 3) == 1) ? C_WR : C_RD;
        adrK[k] = ADDR_W'((k * 3) & 15);
      end
    end
    for (int i = 0; i < DEPTH; i++) refMem[i] = '0;
    for (int k = 0; k < NK; k++) begin
      if (cmdK[k] == C_RD) begin
        numReads++;
        e0K[k] = refMem[adrK[k]];
        e1K[k] = refMem[adrK[k] ^ 4'd1];
      end else begin
        e0K[k] = '0; e1K[k] = '0;
      end
      if (cmdK[k] == C_WR) begin
        refMem[adrK[k]]        = w0K[k];
        refMem[adrK[k] ^ 4'd1] = w1K[k];
      end
    end
  endtask

  task automatic drive(input int e);
    int k;
    k = e / 2;
    if (e % 2 == 0) begin
      // R3: command encoding on K-rise edges
      ldN  = (cmdK[k] == C_IDLE);
      rwN  = (cmdK[k] != C_WR);
      addr = adrK[k];
    end else begin
      // R2: arbitrary values on K# edges must be ignored
      ldN  = 1'b0;
      rwN  = e[1];
      addr = ADDR_W'(e * 7);
    end
    // R5: write words due on edges e+2 and e+3 of the command
    if (k >= 1 && cmdK[k-1] == C_WR) dIn = (e % 2 == 0) ? w0K[k-1] : w1K[k-1];
    else dIn = DATA_W'(e * 13 + 1);
  endtask

  task automatic checkEdge(input int e);
    int k, src;
    logic expOe;
    logic [DATA_W-1:0] expD;
    string tag;
    k = e / 2;
    expOe = 0; expD = '0; src = -1;
    if (e % 2 == 1 && k >= 1 && cmdK[k-1] == C_RD) begin
      expOe = 1; src = k - 1; expD = e0K[src];
    end else if (e % 2 == 0 && k >= 2 && cmdK[k-2] == C_RD) begin
      expOe = 1; src = k - 2; expD = e1K[src];
    end
    if (oe) oeSlots++;
    if (!expOe) begin
      check("R6 oe off", {7'd0, oe}, {7'd0, expOe}, e);
      check("R8 dOut idle", dOut, '0, e);
    end else begin
      if (src == 0) tag = "R9 reset contents";
      else if (fwdK[src]) tag = "R7 forwarded";
      else if (src >= 18 && src < 34) tag = "R5 written data";
      else if (e % 2 == 0) tag = "R1 second beat";
      else tag = "R4 first beat";
      check({tag, " oe"}, {7'd0, oe}, {7'd0, expOe}, e);
      check(tag, dOut, expD, e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    summary();
  end

  initial begin
    buildProgram();
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset oe", {7'd0, oe}, 8'd0, -1);
    check("R9 reset dOut", dOut, '0, -1);
    rstN = 1'b1;
    for (int e = 0; e < NE; e++) begin
      drive(e);
      @(posedge clk);
      @(negedge clk);
      checkEdge(e);
    end
    // R2 R3: exactly two driven slots per decoded read, none from K# inputs
    check("R2 R3 driven slot count", DATA_W'(oeSlots), DATA_W'(2 * numReads), NE);
    summary();
  end

endmodule